// File: doc/BRIEF.md
# Operand and Branch-Target Trace Nibble Serializer

This block turns processor bus operands and taken-branch target addresses into a stream of 4-bit trace symbols, one per clock. Each accepted event becomes a record: a one-nibble marker that names the record type and length, followed by the payload nibbles. A two-bit capture mode picks which bus accesses are recorded (none, writes, reads or both). A two-bit branch mode picks whether a taken-branch target is recorded, and whether 2 or 3 of its low bytes are sent.

Records go through a small queue, so events that arrive while a record is still being shifted out are not lost. When the queue has no room, the event is discarded and a sticky overflow flag is raised. Both mode fields are sampled only at a record boundary. A record already on the port always finishes whole.

Top module: `trace_operand_serializer`

## Requirements
- R1: Capture mode `cap_mode` 2'b00 records no operand, 2'b01 records writes only (`acc_write`=1), 2'b10 records reads only, and 2'b11 records both.
- R2: An operand record is a marker nibble followed by data nibbles. For `acc_size` 0 (byte) the marker is 0x8 with 2 nibbles. For size 1 (word) it is 0x9 with 4 nibbles. For size 2 (long) it is 0xB with 8 nibbles. An access with size code 3 is ignored.
- R3: Payload nibbles leave least-significant first: data bits [3:0], then [7:4], and so on. Bits above the operand size never appear.
- R4: Branch mode `br_mode` 2'b00 records no target. 2'b01 sends marker 0xA and the 4 low nibbles of `br_target`. 2'b10 and 2'b11 send marker 0xC and the 6 low nibbles.
- R5: After reset, and whenever no record is being sent, `trc_valid` is 0 and `trc_nibble` is 0x0. Reset clears `trc_ovf`.
- R6: An event sampled at a rising edge with the port idle puts its marker on the port after the next rising edge. Queued records follow one another with no idle cycle between them.
- R7: The queue holds 4 records beyond the one being sent. An event that finds no room is dropped, and `trc_ovf` is set and stays set until reset.
- R8: When an operand and a branch target are accepted in the same cycle, the operand record is sent first.
- R9: A change to `cap_mode` or `br_mode` takes effect only at a record boundary. An event that arrives while a record is being sent is filtered by the mode in force for that record, and no record is ever shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Bus access event this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read |
| acc_size | input | 2 | Operand size: 0 byte, 1 word, 2 long, 3 reserved |
| acc_data | input | 32 | Operand data, right-aligned |
| br_valid | input | 1 | Taken-branch event this cycle |
| br_target | input | 32 | Branch target address |
| cap_mode | input | 2 | Operand capture mode |
| br_mode | input | 2 | Branch target byte count mode |
| trc_nibble | output | 4 | Trace symbol |
| trc_valid | output | 1 | Trace symbol is part of a record |
| trc_ovf | output | 1 | Sticky queue overflow |

## Verification
A wrong nibble counter shows up within one record: the port either drops back to idle early, which cuts the record short, or carries one nibble too many. The next symbol is then read as a marker and decodes to a value that is not a legal marker. A bad queue pointer or occupancy count shows up as a repeated, missing or reordered record once four or five events are queued, or as `trc_ovf` rising one event too early or too late. A stale mode register shows up in the very next record, because that record is filtered or sized with the wrong setting.

// File: rtl/trace_ser_pkg.sv
package trace_ser_pkg;
  localparam int unsigned TRC_DW  = 32;
  localparam int unsigned TRC_NMAX = TRC_DW / 4;
  localparam int unsigned TRC_CW  = $clog2(TRC_NMAX + 1);

  localparam logic [3:0] MK_BYTE = 4'h8;
  localparam logic [3:0] MK_WORD = 4'h9;
  localparam logic [3:0] MK_BR2  = 4'hA;
  localparam logic [3:0] MK_LONG = 4'hB;
  localparam logic [3:0] MK_BR3  = 4'hC;

  typedef struct packed {
    logic [3:0]        mark;
    logic [TRC_CW-1:0] nnib;
    logic [TRC_DW-1:0] data;
  } trc_rec_t;
endpackage

// File: rtl/trace_capture_filter.sv
module trace_capture_filter
  import trace_ser_pkg::*;
(
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic [TRC_DW-1:0] acc_data,
  input  logic              br_valid,
  input  logic [TRC_DW-1:0] br_target,
  input  logic [1:0]        cap_mode,
  input  logic [1:0]        br_mode,
  output logic              op_push,
  output trc_rec_t          op_rec,
  output logic              br_push,
  output trc_rec_t          br_rec
);
  always_comb begin
    op_push = acc_valid && (acc_size != 2'b11) &&
              (acc_write ? cap_mode[0] : cap_mode[1]);
    op_rec.data = acc_data;
    unique case (acc_size)
      2'd0:    begin op_rec.mark = MK_BYTE; op_rec.nnib = TRC_CW'(2); end
      2'd1:    begin op_rec.mark = MK_WORD; op_rec.nnib = TRC_CW'(4); end
      default: begin op_rec.mark = MK_LONG; op_rec.nnib = TRC_CW'(8); end
    endcase

    br_push = br_valid && (br_mode != 2'b00);
    br_rec.data = br_target;
    if (br_mode[1]) begin
      br_rec.mark = MK_BR3;
      br_rec.nnib = TRC_CW'(6);
    end else begin
      br_rec.mark = MK_BR2;
      br_rec.nnib = TRC_CW'(4);
    end
  end
endmodule

// File: rtl/trace_rec_fifo.sv
module trace_rec_fifo
  import trace_ser_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push_a,
  input  trc_rec_t rec_a,
  input  logic     push_b,
  input  trc_rec_t rec_b,
  input  logic     pop,
  output trc_rec_t head,
  output logic     empty,
  output logic     drop
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n, wr_b_ptr;
  logic [CNT_W-1:0] cnt_q, cnt_n, free;
  logic             take_a, take_b, do_pop;
  trc_rec_t         slot_w [DEPTH];

  always_comb begin
    free     = CNT_W'(DEPTH) - cnt_q;
    take_a   = push_a && (free >= CNT_W'(1));
    take_b   = push_b && (free >= (take_a ? CNT_W'(2) : CNT_W'(1)));
    drop     = (push_a && !take_a) || (push_b && !take_b);
    empty    = (cnt_q == '0);
    do_pop   = pop && !empty;
    wr_b_ptr = wr_ptr_q + PTR_W'(take_a);
    wr_ptr_n = wr_ptr_q + PTR_W'(take_a) + PTR_W'(take_b);
    rd_ptr_n = rd_ptr_q + PTR_W'(do_pop);
    cnt_n    = cnt_q + CNT_W'(take_a) + CNT_W'(take_b) - CNT_W'(do_pop);
    head     = slot_w[rd_ptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic     we_a, we_b;
    trc_rec_t slot_q;
    assign we_a = take_a && (wr_ptr_q == PTR_W'(i));
    assign we_b = take_b && (wr_b_ptr == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (we_a)      slot_q <= rec_a;
      else if (we_b) slot_q <= rec_b;
    end
    assign slot_w[i] = slot_q;
  end
endmodule

// File: rtl/trace_nibble_shifter.sv
module trace_nibble_shifter
  import trace_ser_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  trc_rec_t head,
  input  logic     empty,
  output logic     pop,
  output logic     boundary,
  output logic [3:0] nibble,
  output logic     valid
);
  logic              busy_q, busy_n;
  logic [TRC_CW-1:0] rem_q, rem_n;
  logic [TRC_DW-1:0] sh_q, sh_n;
  logic [3:0]        nib_q, nib_n;

  always_comb begin
    boundary = !busy_q || (rem_q == '0);
    pop      = boundary && !empty;
    busy_n   = busy_q;
    rem_n    = rem_q;
    sh_n     = sh_q;
    nib_n    = nib_q;
    if (pop) begin
      busy_n = 1'b1;
      nib_n  = head.mark;
      sh_n   = head.data;
      rem_n  = head.nnib;
    end else if (busy_q && (rem_q != '0)) begin
      nib_n  = sh_q[3:0];
      sh_n   = {4'h0, sh_q[TRC_DW-1:4]};
      rem_n  = rem_q - TRC_CW'(1);
    end else begin
      busy_n = 1'b0;
      nib_n  = 4'h0;
      rem_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      sh_q   <= '0;
      nib_q  <= 4'h0;
    end else begin
      busy_q <= busy_n;
      rem_q  <= rem_n;
      sh_q   <= sh_n;
      nib_q  <= nib_n;
    end
  end

  assign nibble = nib_q;
  assign valid  = busy_q;
endmodule

// File: rtl/trace_operand_serializer.sv
module trace_operand_serializer
  import trace_ser_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_data,
  input  logic        br_valid,
  input  logic [31:0] br_target,
  input  logic [1:0]  cap_mode,
  input  logic [1:0]  br_mode,
  output logic [3:0]  trc_nibble,
  output logic        trc_valid,
  output logic        trc_ovf
);
  logic [1:0] cap_q, cap_n, brm_q, brm_n;
  logic       ovf_q, ovf_n;
  logic       op_push, br_push, pop, empty, drop, boundary;
  trc_rec_t   op_rec, br_rec, head;

  trace_capture_filter u_filt (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_size  (acc_size),
    .acc_data  (acc_data),
    .br_valid  (br_valid),
    .br_target (br_target),
    .cap_mode  (cap_q),
    .br_mode   (brm_q),
    .op_push   (op_push),
    .op_rec    (op_rec),
    .br_push   (br_push),
    .br_rec    (br_rec)
  );

  trace_rec_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_a (op_push),
    .rec_a  (op_rec),
    .push_b (br_push),
    .rec_b  (br_rec),
    .pop    (pop),
    .head   (head),
    .empty  (empty),
    .drop   (drop)
  );

  trace_nibble_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .head     (head),
    .empty    (empty),
    .pop      (pop),
    .boundary (boundary),
    .nibble   (trc_nibble),
    .valid    (trc_valid)
  );

  always_comb begin
    cap_n = boundary ? cap_mode : cap_q;
    brm_n = boundary ? br_mode  : brm_q;
    ovf_n = ovf_q | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 2'b00;
      brm_q <= 2'b00;
      ovf_q <= 1'b0;
    end else begin
      cap_q <= cap_n;
      brm_q <= brm_n;
      ovf_q <= ovf_n;
    end
  end

  assign trc_ovf = ovf_q;
endmodule

// File: rtl/trace_operand_serializer_chk.sv
module trace_operand_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] trc_nibble,
  input logic       trc_valid,
  input logic       trc_ovf
);
  logic [3:0] left_q;

  function automatic logic [3:0] mark_len(input logic [3:0] m);
    case (m)
      4'h8:    mark_len = 4'd2;
      4'h9:    mark_len = 4'd4;
      4'hA:    mark_len = 4'd4;
      4'hB:    mark_len = 4'd8;
      4'hC:    mark_len = 4'd6;
      default: mark_len = 4'd0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= 4'd0;
    else if (left_q != 4'd0)  left_q <= left_q - 4'd1;
    else if (trc_valid)       left_q <= mark_len(trc_nibble);
  end

  // R2, R4: every record opens with a legal marker
  p_marker_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid && left_q == 4'd0) |-> (mark_len(trc_nibble) != 4'd0));

  // R9: a started record runs to its full length
  p_no_truncate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q != 4'd0) |-> trc_valid);

  // R5: idle port carries zero
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !trc_valid |-> (trc_nibble == 4'h0));

  // R7: overflow flag is sticky
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trc_ovf |=> trc_ovf);
endmodule

bind trace_operand_serializer trace_operand_serializer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trc_nibble (trc_nibble),
  .trc_valid  (trc_valid),
  .trc_ovf    (trc_ovf)
);

// File: tb/sim_trace_operand_serializer.sv
`timescale 1ns/1ps
module sim_trace_operand_serializer;
  logic        clk;
  logic        rst_n;
  logic        acc_valid, acc_write, br_valid;
  logic [1:0]  acc_size, cap_mode, br_mode;
  logic [31:0] acc_data, br_target;
  logic [3:0]  trc_nibble;
  logic        trc_valid, trc_ovf;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  trace_operand_serializer u0 (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
    .acc_data(acc_data), .br_valid(br_valid), .br_target(br_target),
    .cap_mode(cap_mode), .br_mode(br_mode),
    .trc_nibble(trc_nibble), .trc_valid(trc_valid), .trc_ovf(trc_ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0]  cap;
    logic [1:0]  brm;
    logic        is_br;
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] d;
    logic [3:0]  mk;
    logic [3:0]  n;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 2'b00, 1'b0, 1'b1, 2'd0, 32'hFFFF_FFA5, 4'h8, 4'd2},
    '{2'b01, 2'b00, 1'b0, 1'b0, 2'd0, 32'h0000_0011, 4'h0, 4'd0},
    '{2'b10, 2'b00, 1'b0, 1'b0, 2'd1, 32'hDEAD_1234, 4'h9, 4'd4},
    '{2'b10, 2'b00, 1'b0, 1'b1, 2'd1, 32'h0000_5678, 4'h0, 4'd0},
    '{2'b11, 2'b00, 1'b0, 1'b0, 2'd2, 32'h89AB_CDEF, 4'hB, 4'd8},
    '{2'b11, 2'b00, 1'b0, 1'b1, 2'd2, 32'h1357_9BDF, 4'hB, 4'd8},
    '{2'b00, 2'b00, 1'b0, 1'b1, 2'd2, 32'h2468_ACE0, 4'h0, 4'd0},
    '{2'b11, 2'b00, 1'b0, 1'b1, 2'd3, 32'h1111_2222, 4'h0, 4'd0},
    '{2'b00, 2'b00, 1'b1, 1'b0, 2'd0, 32'h00AB_CDEF, 4'h0, 4'd0},
    '{2'b00, 2'b01, 1'b1, 1'b0, 2'd0, 32'h00AB_CDEF, 4'hA, 4'd4},
    '{2'b00, 2'b10, 1'b1, 1'b0, 2'd0, 32'h00AB_CDEF, 4'hC, 4'd6},
    '{2'b00, 2'b11, 1'b1, 1'b0, 2'd0, 32'h9912_3456, 4'hC, 4'd6}
  };

  // collector of port symbols, sampled on the falling edge
  logic [3:0] cap [64];
  int ccnt = 0;
  int cyc = 0;
  int first_cyc = 0;
  int last_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (trc_valid && ccnt < 64) begin
      cap[ccnt] = trc_nibble;
      if (ccnt == 0) first_cyc = cyc;
      last_cyc = cyc;
      ccnt = ccnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clr_coll();
    ccnt = 0;
  endtask

  task automatic idle_inputs();
    acc_valid = 1'b0; acc_write = 1'b0; acc_size = 2'd0; acc_data = '0;
    br_valid = 1'b0; br_target = '0;
  endtask

  task automatic expect_rec(input int base, input logic [3:0] mk, input int n,
                            input logic [31:0] d, input string req);
    chk(cap[base] == mk, req, cap[base], mk);
    for (int i = 0; i < n; i++)
      chk(cap[base+1+i] == d[4*i +: 4], req, cap[base+1+i], d[4*i +: 4]);
  endtask

  task automatic run_vec(input vec_t v);
    string req;
    req = v.is_br ? "R4" : "R1/R2/R3";
    cap_mode = v.cap; br_mode = v.brm;
    repeat (3) @(negedge clk);
    clr_coll();
    if (v.is_br) begin
      br_valid = 1'b1; br_target = v.d;
    end else begin
      acc_valid = 1'b1; acc_write = v.wr; acc_size = v.sz; acc_data = v.d;
    end
    @(negedge clk);
    idle_inputs();
    repeat (14) @(negedge clk);
    chk(ccnt == ((v.n == 0) ? 0 : v.n + 1), req, ccnt, (v.n == 0) ? 0 : v.n + 1);
    if (v.n != 0 && ccnt == v.n + 1) expect_rec(0, v.mk, v.n, v.d, req);
  endtask

  task automatic burst_longs(input int k);
    for (int i = 0; i < k; i++) begin
      acc_valid = 1'b1; acc_write = 1'b1; acc_size = 2'd2;
      acc_data = 32'h1000_0000 * (i + 1) + 32'h0765_4321;
      @(negedge clk);
    end
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    cap_mode = 2'b00; br_mode = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R5: reset state
    chk(trc_valid == 1'b0, "R5", trc_valid, 0);
    chk(trc_nibble == 4'h0, "R5", trc_nibble, 0);
    chk(trc_ovf == 1'b0, "R5", trc_ovf, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) run_vec(VECS[v]);

    // R6: latency from event to marker
    cap_mode = 2'b11; br_mode = 2'b00;
    repeat (3) @(negedge clk);
    clr_coll();
    acc_valid = 1'b1; acc_write = 1'b0; acc_size = 2'd2; acc_data = 32'hCAFE_F00D;
    @(negedge clk);
    idle_inputs();
    chk(trc_valid == 1'b0, "R6", trc_valid, 0);
    @(negedge clk);
    chk(trc_valid == 1'b1 && trc_nibble == 4'hB, "R6", trc_nibble, 4'hB);
    repeat (12) @(negedge clk);
    // R5: port idle after record
    chk(trc_valid == 1'b0 && trc_nibble == 4'h0, "R5", trc_nibble, 0);

    // R6, R7: five back-to-back longs fit, no gap, no overflow
    clr_coll();
    burst_longs(5);
    repeat (55) @(negedge clk);
    chk(ccnt == 45, "R6", ccnt, 45);
    chk(last_cyc - first_cyc + 1 == 45, "R6", last_cyc - first_cyc + 1, 45);
    for (int i = 0; i < 5; i++)
      if (ccnt == 45)
        expect_rec(9*i, 4'hB, 8, 32'h1000_0000 * (i + 1) + 32'h0765_4321, "R6");
    chk(trc_ovf == 1'b0, "R7", trc_ovf, 0);

    // R7: sixth long overflows, is dropped, flag sticks
    clr_coll();
    burst_longs(6);
    repeat (60) @(negedge clk);
    chk(ccnt == 45, "R7", ccnt, 45);
    chk(trc_ovf == 1'b1, "R7", trc_ovf, 1);
    repeat (10) @(negedge clk);
    chk(trc_ovf == 1'b1, "R7", trc_ovf, 1);

    // R8: operand and branch in the same cycle
    cap_mode = 2'b11; br_mode = 2'b01;
    repeat (3) @(negedge clk);
    clr_coll();
    acc_valid = 1'b1; acc_write = 1'b1; acc_size = 2'd1; acc_data = 32'h0000_BEEF;
    br_valid = 1'b1; br_target = 32'h0000_4321;
    @(negedge clk);
    idle_inputs();
    repeat (16) @(negedge clk);
    chk(ccnt == 10, "R8", ccnt, 10);
    if (ccnt == 10) begin
      expect_rec(0, 4'h9, 4, 32'h0000_BEEF, "R8");
      expect_rec(5, 4'hA, 4, 32'h0000_4321, "R8");
    end

    // R9: mode change mid-record waits for the boundary
    cap_mode = 2'b01; br_mode = 2'b00;
    repeat (3) @(negedge clk);
    clr_coll();
    acc_valid = 1'b1; acc_write = 1'b1; acc_size = 2'd2; acc_data = 32'h7654_3210;
    @(negedge clk);
    idle_inputs();
    repeat (3) @(negedge clk);
    cap_mode = 2'b00;
    acc_valid = 1'b1; acc_write = 1'b1; acc_size = 2'd0; acc_data = 32'h0000_005A;
    @(negedge clk);
    idle_inputs();
    repeat (20) @(negedge clk);
    chk(ccnt == 12, "R9", ccnt, 12);
    chk(last_cyc - first_cyc + 1 == 12, "R9", last_cyc - first_cyc + 1, 12);
    if (ccnt == 12) begin
      expect_rec(0, 4'hB, 8, 32'h7654_3210, "R9");
      expect_rec(9, 4'h8, 2, 32'h0000_005A, "R9");
    end
    clr_coll();
    acc_valid = 1'b1; acc_write = 1'b1; acc_size = 2'd0; acc_data = 32'h0000_0077;
    @(negedge clk);
    idle_inputs();
    repeat (8) @(negedge clk);
    chk(ccnt == 0, "R9", ccnt, 0);

    // R5: reset during a record clears the port and the flag
    cap_mode = 2'b11;
    repeat (3) @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_size = 2'd2; acc_data = 32'hFFFF_FFFF;
    @(negedge clk);
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(trc_valid == 1'b0 && trc_nibble == 4'h0, "R5", trc_nibble, 0);
    chk(trc_ovf == 1'b0, "R5", trc_ovf, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule